// File: doc/BRIEF.md
# Inline-Data Pitch-Linear Memory Writer

This engine takes a rectangular patch of bytes and writes it into memory. Software sets up the transfer through a 32-bit register write port: the byte length of a line, the number of lines, a 40-bit destination base, the row pitch and a 2D origin. A launch write then opens a collection window. The payload itself does not come from memory. Software pushes it one 32-bit word at a time by writing an inline-data register, and the engine keeps each word in a local buffer.

Once enough words have arrived to cover length × lines bytes, the engine walks the destination one line at a time. Within a line it emits whole 16-byte beats while at least 16 bytes of the line remain, then writes the rest one byte per beat. Beats go out on a valid/ready write port. A one-cycle done pulse marks the end of the transfer. A single-line pitch-linear transfer ignores the origin and lands contiguously at the base.

Top module: `inline_mem_writer`

## Requirements
- R1: After reset, mem_valid_o, done_o and err_o are low.
- R2: Register byte offsets are:
  - 0x180: line length in bytes.
  - 0x184: line count.
  - 0x188: address bits [39:32], taken from data bits [7:0].
  - 0x18C: address bits [31:0].
  - 0x190: pitch.
  - 0x1A8: X origin, data bits [19:0].
  - 0x1AC: Y origin, data bits [15:0].
  - 0x1B0: launch.
  - 0x1B4: inline data.

  Upper bits of the address, origin X and origin Y writes are dropped.
- R3: After a launch, each inline-data write stores one word. When words × 4 ≥ length × lines, the write phase starts. Payload bytes are taken in little-endian order within a word. Bytes past length × lines in the last word are never written.
- R4: Lines go in increasing order. Within a line, beats are 16-byte chunks while 16 or more bytes of the line remain, then single bytes. The beat address is base + (originY + line) × pitch + originX + column.
- R5: Launch data bit 0 = 1 selects pitch-linear layout. With pitch-linear layout and a line count of 1, the origin is ignored and the payload goes to base + offset.
- R6: Launch data bit 0 = 0 (block-linear) with a line count of 1 follows the walk of R4, origin included.
- R7: A launch is rejected when it is block-linear with more than one line, or when length × lines exceeds the buffer (256 bytes by default). A rejected launch sets err_o and produces no beats and no done. Inline writes after it are ignored. The next accepted launch clears err_o.
- R8: While mem_valid_o is high and mem_ready_i is low, the address, data and size outputs hold steady and valid stays high.
- R9: done_o pulses for one cycle after the final beat is accepted. A launch whose size is zero pulses done_o the cycle after the launch, with no beats.
- R10: Inline-data writes that arrive after a transfer has completed produce no beat and no done.
- R11: A launch written during the write phase is ignored; the running transfer finishes unchanged.
- R12: A launch during the collection phase restarts collection at word zero with the new configuration.
- R13: On a 16-byte beat, mem_wide_o = 1 and byte k sits in mem_data_o[8k+7:8k]. On a single-byte beat, mem_wide_o = 0, the byte sits in [7:0] and bits [127:8] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Write beat accepted |
| mem_addr_o | output | 40 | Beat byte address |
| mem_data_o | output | 128 | Beat data, little-endian |
| mem_wide_o | output | 1 | 1 = 16-byte beat, 0 = single byte |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Last launch rejected |

## Verification
The walk is tried with several shapes, and each one isolates a different part of it:
- A multi-line pitch transfer with an odd line length and a nonzero origin covers both the chunk/tail split and the row stepping.
- A single-line pitch transfer differs from a single-line block-linear one only in whether the origin applies.
- A 256-byte transfer exercises the buffer bound.
- A 6-byte transfer leaves stray bytes in its last word, which shows whether those bytes are discarded.

Ready is throttled by a pseudo-random pattern in most runs, so stalls fall on both wide and single-byte beats. Launches placed mid-collection and mid-write, zero-size launches, rejected launches and late inline writes check the control sequencing against a scoreboard of expected beats.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int REG_AW     = 12;
  localparam int DST_AW     = 40;
  localparam int BEAT_BYTES = 16;

  localparam logic [REG_AW-1:0] OFF_LEN     = 12'h180;
  localparam logic [REG_AW-1:0] OFF_LINES   = 12'h184;
  localparam logic [REG_AW-1:0] OFF_ADDR_HI = 12'h188;
  localparam logic [REG_AW-1:0] OFF_ADDR_LO = 12'h18C;
  localparam logic [REG_AW-1:0] OFF_PITCH   = 12'h190;
  localparam logic [REG_AW-1:0] OFF_ORG_X   = 12'h1A8;
  localparam logic [REG_AW-1:0] OFF_ORG_Y   = 12'h1AC;
  localparam logic [REG_AW-1:0] OFF_LAUNCH  = 12'h1B0;
  localparam logic [REG_AW-1:0] OFF_DATA    = 12'h1B4;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_WRITE} seq_st_e;

  typedef struct packed {
    logic [31:0]       len;
    logic [31:0]       lines;
    logic [DST_AW-1:0] base;
    logic [31:0]       pitch;
    logic [19:0]       org_x;
    logic [15:0]       org_y;
  } xfer_cfg_t;
endpackage

// File: rtl/iw_regs.sv
module iw_regs
  import iw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output xfer_cfg_t         cfg_o,
  output logic              launch_o,
  output logic              launch_pitch_o,
  output logic              push_o,
  output logic [31:0]       push_data_o
);
  xfer_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_LEN:     cfg_q.len                       <= wdata_i;
        OFF_LINES:   cfg_q.lines                     <= wdata_i;
        OFF_ADDR_HI: cfg_q.base[DST_AW-1:32]         <= wdata_i[DST_AW-33:0];
        OFF_ADDR_LO: cfg_q.base[31:0]                <= wdata_i;
        OFF_PITCH:   cfg_q.pitch                     <= wdata_i;
        OFF_ORG_X:   cfg_q.org_x                     <= wdata_i[19:0];
        OFF_ORG_Y:   cfg_q.org_y                     <= wdata_i[15:0];
        default: ;
      endcase
    end
  end

  assign cfg_o          = cfg_q;
  assign launch_o       = we_i && (addr_i == OFF_LAUNCH);
  assign launch_pitch_o = wdata_i[0];
  assign push_o         = we_i && (addr_i == OFF_DATA);
  assign push_data_o    = wdata_i;
endmodule

// File: rtl/iw_buf.sv
module iw_buf
  import iw_pkg::*;
#(
  parameter  int WORDS  = 64,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORDS * 4)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [WIDX_W-1:0]       widx_i,
  input  logic [31:0]             wdata_i,
  input  logic [BYTE_W-1:0]       rd_off_i,
  output logic [BEAT_BYTES*8-1:0] rd_data_o
);
  localparam logic [BYTE_W:0] LIM = (BYTE_W+1)'(WORDS * 4);

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
    logic [BYTE_W:0] idx;
    assign idx = {1'b0, rd_off_i} + (BYTE_W+1)'(k);
    assign rd_data_o[8*k +: 8] = (idx < LIM) ?
        mem_q[idx[BYTE_W-1:2]][{idx[1:0], 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/iw_seq.sv
module iw_seq
  import iw_pkg::*;
#(
  parameter  int WORDS  = 64,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORDS * 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_cfg_t         cfg_i,
  input  logic              launch_i,
  input  logic              launch_pitch_i,
  input  logic              push_i,
  input  logic              ready_i,
  output logic              buf_we_o,
  output logic [WIDX_W-1:0] buf_widx_o,
  output logic [BYTE_W-1:0] rd_off_o,
  output logic              valid_o,
  output logic [DST_AW-1:0] addr_o,
  output logic              wide_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int BUF_BYTES = WORDS * 4;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  size_q, len_q, lines_q, need_q, wcnt_q, col_q, row_q, src_q;
  logic [31:0]       pitch_q;
  logic [DST_AW-1:0] line_addr_q;
  logic              done_q, err_q;

  // launch evaluation
  logic [63:0]       size64;
  logic              reject, contig;
  logic [DST_AW-1:0] start_addr;
  logic [CNT_W:0]    need_w;

  assign size64     = 64'(cfg_i.len) * 64'(cfg_i.lines);
  assign reject     = (!launch_pitch_i && cfg_i.lines > 32'd1) || (size64 > 64'(BUF_BYTES));
  assign contig     = launch_pitch_i && cfg_i.lines == 32'd1;
  assign start_addr = contig ? cfg_i.base
                    : cfg_i.base + DST_AW'(cfg_i.org_y) * DST_AW'(cfg_i.pitch) + DST_AW'(cfg_i.org_x);
  assign need_w     = ((CNT_W+1)'(size64[CNT_W-1:0]) + (CNT_W+1)'(3)) >> 2;

  // beat generation
  logic [CNT_W-1:0] remain, step, col_nx;
  logic             fire;

  assign remain   = len_q - col_q;
  assign wide_o   = remain >= CNT_W'(BEAT_BYTES);
  assign step     = wide_o ? CNT_W'(BEAT_BYTES) : CNT_W'(1);
  assign col_nx   = col_q + step;
  assign valid_o  = st_q == ST_WRITE;
  assign fire     = valid_o && ready_i;
  assign addr_o   = line_addr_q + DST_AW'(col_q);
  assign rd_off_o = src_q[BYTE_W-1:0];

  assign buf_we_o   = push_i && st_q == ST_COLLECT;
  assign buf_widx_o = wcnt_q[WIDX_W-1:0];
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      size_q      <= '0;
      len_q       <= '0;
      lines_q     <= '0;
      need_q      <= '0;
      wcnt_q      <= '0;
      col_q       <= '0;
      row_q       <= '0;
      src_q       <= '0;
      pitch_q     <= '0;
      line_addr_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_i && st_q != ST_WRITE) begin
        if (reject) begin
          err_q <= 1'b1;
          st_q  <= ST_IDLE;
        end else begin
          err_q       <= 1'b0;
          size_q      <= size64[CNT_W-1:0];
          len_q       <= cfg_i.len[CNT_W-1:0];
          lines_q     <= cfg_i.lines[CNT_W-1:0];
          need_q      <= need_w[CNT_W-1:0];
          pitch_q     <= cfg_i.pitch;
          line_addr_q <= start_addr;
          wcnt_q      <= '0;
          col_q       <= '0;
          row_q       <= '0;
          src_q       <= '0;
          if (size64 == 64'd0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_COLLECT;
          end
        end
      end else if (buf_we_o) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (wcnt_q + 1'b1 >= need_q) st_q <= ST_WRITE;
      end else if (fire) begin
        src_q <= src_q + step;
        if (col_nx == len_q) begin
          col_q       <= '0;
          row_q       <= row_q + 1'b1;
          line_addr_q <= line_addr_q + DST_AW'(pitch_q);
          if (row_q + 1'b1 == lines_q) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end else begin
          col_q <= col_nx;
        end
      end
    end
  end

  p_collect_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_COLLECT |-> wcnt_q < need_q);
  p_src_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> src_q < size_q);
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);
  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(wide_o) && $stable(src_q));
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  p_launch_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && valid_o |=> $stable(len_q) && $stable(lines_q) && $stable(size_q));
endmodule

// File: rtl/inline_mem_writer.sv
module inline_mem_writer
  import iw_pkg::*;
#(
  parameter int BUF_WORDS = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [DST_AW-1:0]       mem_addr_o,
  output logic [BEAT_BYTES*8-1:0] mem_data_o,
  output logic                    mem_wide_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam int WIDX_W = $clog2(BUF_WORDS);
  localparam int BYTE_W = $clog2(BUF_WORDS * 4);

  xfer_cfg_t                cfg;
  logic                     launch, launch_pitch, push, buf_we;
  logic [31:0]              push_data;
  logic [WIDX_W-1:0]        buf_widx;
  logic [BYTE_W-1:0]        rd_off;
  logic [BEAT_BYTES*8-1:0]  rd_data;

  iw_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .launch_o(launch), .launch_pitch_o(launch_pitch),
    .push_o(push), .push_data_o(push_data)
  );

  iw_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk_i, .we_i(buf_we), .widx_i(buf_widx), .wdata_i(push_data),
    .rd_off_i(rd_off), .rd_data_o(rd_data)
  );

  iw_seq #(.WORDS(BUF_WORDS)) u_seq (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .launch_i(launch), .launch_pitch_i(launch_pitch), .push_i(push),
    .ready_i(mem_ready_i), .buf_we_o(buf_we), .buf_widx_o(buf_widx),
    .rd_off_o(rd_off), .valid_o(mem_valid_o), .addr_o(mem_addr_o),
    .wide_o(mem_wide_o), .done_o(done_o), .err_o(err_o)
  );

  // single-byte beats carry lane 0 only
  assign mem_data_o = mem_wide_o ? rd_data : {{(BEAT_BYTES*8-8){1'b0}}, rd_data[7:0]};

  p_done_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
endmodule

// File: tb/tb_inline_mem_writer.sv
`timescale 1ns/1ps
module tb_inline_mem_writer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         ready = 1'b0;
  logic         valid, wide, done, err;
  logic [39:0]  maddr;
  logic [127:0] mdata;

  always #2.5 clk = ~clk;

  inline_mem_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .mem_valid_o(valid), .mem_ready_i(ready), .mem_addr_o(maddr), .mem_data_o(mdata),
    .mem_wide_o(wide), .done_o(done), .err_o(err)
  );

  int n_checks = 0, n_fail = 0, done_cnt = 0, beat_cnt = 0;
  logic [39:0]  exp_addr_q[$];
  logic [127:0] exp_data_q[$];
  logic         exp_wide_q[$];
  logic [7:0]   pay [256];
  logic         stall_all = 1'b0;
  logic [7:0]   lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready <= rst_n && !stall_all && (lfsr[0] | lfsr[2]);
  end

  // monitor
  logic         pv = 1'b0, pr = 1'b0, pw = 1'b0;
  logic [39:0]  pa = '0;
  logic [127:0] pd = '0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (pv && !pr)
        chk(valid && maddr == pa && mdata == pd && wide == pw, "R8",
            $sformatf("stall hold act v%0b a%h w%0b exp a%h w%0b", valid, maddr, wide, pa, pw));
      if (valid && ready) begin
        beat_cnt++;
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R4", $sformatf("unexpected beat act a%h exp none", maddr));
        end else begin
          logic [39:0]  ea;
          logic [127:0] ed;
          logic         ew;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          ew = exp_wide_q.pop_front();
          chk(maddr == ea && mdata == ed && wide == ew, "R4/R13",
              $sformatf("beat act a%h w%0b d%h exp a%h w%0b d%h", maddr, wide, mdata, ea, ew, ed));
        end
      end
      if (done) done_cnt++;
      pv = valid; pr = ready; pa = maddr; pd = mdata; pw = wide;
    end
  end

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++) pay[i] = 8'(i * 37 + seed * 11 + (i >> 3) * seed + 3);
  endtask

  task automatic load_cfg(input int len, input int lines, input logic [39:0] base,
                          input int pitch, input int ox, input int oy);
    reg_wr(12'h180, 32'(len));
    reg_wr(12'h184, 32'(lines));
    reg_wr(12'h188, {24'hA5C3F1, base[39:32]});  // R2: only [7:0] used
    reg_wr(12'h18C, base[31:0]);
    reg_wr(12'h190, 32'(pitch));
    reg_wr(12'h1A8, 32'hFFF0_0000 | 32'(ox));    // R2: bits [19:0]
    reg_wr(12'h1AC, 32'hBEEF_0000 | 32'(oy));    // R2: bits [15:0]
  endtask

  task automatic expect_xfer(input int len, input int lines, input logic [39:0] base,
                             input int pitch, input int ox, input int oy, input bit pm);
    int src = 0;
    for (int r = 0; r < lines; r++) begin
      int col = 0;
      while (col < len) begin
        logic [39:0]  a;
        logic [127:0] d = '0;
        bit w = (len - col) >= 16;
        if (pm && lines == 1) a = base + 40'(col);
        else a = base + 40'(oy + r) * 40'(pitch) + 40'(ox) + 40'(col);
        if (w) for (int k = 0; k < 16; k++) d[8*k +: 8] = pay[src + k];
        else d[7:0] = pay[src];
        exp_addr_q.push_back(a); exp_data_q.push_back(d); exp_wide_q.push_back(w);
        col += w ? 16 : 1;
        src += w ? 16 : 1;
      end
    end
  endtask

  task automatic send_words(input int n);
    for (int w = 0; w < n; w++)
      reg_wr(12'h1B4, {pay[4*w+3], pay[4*w+2], pay[4*w+1], pay[4*w]});
  endtask

  task automatic wait_done(input int d0, input string req);
    int t = 0;
    while (done_cnt == d0 && t < 4000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, req, $sformatf("done count act %0d exp %0d", done_cnt, d0 + 1));
    chk(exp_addr_q.size() == 0, req, $sformatf("beats left act %0d exp 0", exp_addr_q.size()));
  endtask

  task automatic run(input int len, input int lines, input logic [39:0] base, input int pitch,
                     input int ox, input int oy, input bit pm, input int seed, input string req);
    int d0;
    fill(seed);
    load_cfg(len, lines, base, pitch, ox, oy);
    expect_xfer(len, lines, base, pitch, ox, oy, pm);
    d0 = done_cnt;
    reg_wr(12'h1B0, {31'h0, pm});
    send_words((len * lines + 3) / 4);
    wait_done(d0, req);
    chk(err == 1'b0, req, $sformatf("err act %0b exp 0", err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R9: watchdog expired act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int d0, b0;
    repeat (3) @(negedge clk);
    chk(!valid && !done && !err, "R1", $sformatf("reset act v%0b d%0b e%0b exp 000", valid, done, err));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!valid && !done && !err, "R1", $sformatf("post reset act v%0b d%0b e%0b exp 000", valid, done, err));

    // R2 R3 R4: multi-line pitch, odd length, origin
    run(37, 3, 40'h12_3456_7000, 64, 5, 2, 1'b1, 1, "R4");
    // R5: single line pitch, origin ignored
    run(50, 1, 40'h03_0000_0100, 128, 7, 9, 1'b1, 2, "R5");
    // R6: block-linear single line uses origin
    run(20, 1, 40'h00_8000_0000, 32, 3, 1, 1'b0, 3, "R6");
    // R3: 6 bytes, stray bytes of last word dropped
    run(6, 1, 40'hFF_FFFF_FF00, 16, 0, 0, 1'b1, 4, "R3");
    // R3 R4: full buffer
    run(64, 4, 40'h40_0000_0000, 100, 0, 0, 1'b1, 5, "R3");

    // R10: late inline writes
    d0 = done_cnt; b0 = beat_cnt;
    send_words(3);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 && beat_cnt == b0, "R10",
        $sformatf("late push act d%0d b%0d exp d%0d b%0d", done_cnt, beat_cnt, d0, b0));

    // R7: block-linear multi-line rejected
    load_cfg(8, 2, 40'h0, 16, 0, 0);
    d0 = done_cnt; b0 = beat_cnt;
    reg_wr(12'h1B0, 32'h0);
    chk(err == 1'b1, "R7", $sformatf("layout err act %0b exp 1", err));
    send_words(4);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 && beat_cnt == b0 && !valid, "R7",
        $sformatf("rejected act d%0d b%0d exp d%0d b%0d", done_cnt, beat_cnt, d0, b0));
    // R7: oversize rejected
    load_cfg(100, 3, 40'h0, 128, 0, 0);
    reg_wr(12'h1B0, 32'h1);
    chk(err == 1'b1, "R7", $sformatf("oversize err act %0b exp 1", err));
    send_words(8);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 && beat_cnt == b0, "R7",
        $sformatf("oversize act d%0d b%0d exp d%0d b%0d", done_cnt, beat_cnt, d0, b0));
    // R7: next good launch clears err (run checks err==0)
    run(17, 2, 40'h00_0000_1000, 40, 2, 0, 1'b1, 6, "R7");

    // R9: zero-size launch
    load_cfg(0, 4, 40'h0, 16, 0, 0);
    d0 = done_cnt; b0 = beat_cnt;
    reg_wr(12'h1B0, 32'h1);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && beat_cnt == b0 && !err, "R9",
        $sformatf("zero size act d%0d b%0d exp d%0d b%0d", done_cnt, beat_cnt, d0 + 1, b0));

    // R11: launch during write phase ignored
    stall_all = 1'b1;
    fill(7);
    load_cfg(33, 2, 40'h05_0000_0000, 48, 1, 3);
    expect_xfer(33, 2, 40'h05_0000_0000, 48, 1, 3, 1'b1);
    d0 = done_cnt;
    reg_wr(12'h1B0, 32'h1);
    send_words((33 * 2 + 3) / 4);
    repeat (3) @(negedge clk);
    chk(valid == 1'b1, "R11", $sformatf("write phase act v%0b exp 1", valid));
    load_cfg(4, 1, 40'h0, 16, 0, 0);
    reg_wr(12'h1B0, 32'h1);
    stall_all = 1'b0;
    wait_done(d0, "R11");

    // R12: relaunch during collection
    fill(8);
    load_cfg(40, 1, 40'h0, 16, 0, 0);
    reg_wr(12'h1B0, 32'h1);
    send_words(2);
    fill(9);
    load_cfg(21, 2, 40'h00_0100_0000, 30, 4, 0);
    expect_xfer(21, 2, 40'h00_0100_0000, 30, 4, 0, 1'b1);
    d0 = done_cnt;
    reg_wr(12'h1B0, 32'h1);
    send_words((21 * 2 + 3) / 4);
    wait_done(d0, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule